// File: doc/BRIEF.md
# Programmable-Tap Serial Scrambler

This block is a bit-serial scrambler for a transmit data path. A seven-stage shift register holds the recent history of the line. A tap mask, written through a byte-wide configuration port, picks the stages whose exclusive-OR forms the feedback term. Software therefore chooses the feedback polynomial at run time. It is not fixed in the logic.

Each cycle in which `bit_en` is high takes one data bit and produces one output bit, registered, on the next cycle. The structure is self-synchronizing. In scramble mode the output bit is shifted into the history. In descramble mode the received bit is shifted in instead. For this reason a descrambler with the same mask recovers the data after seven bits, whatever state it started in. A synchronous reset loads a programmable seed into the history and restores the default mask, which encodes 1 + x^-4 + x^-7. The default mask is therefore 48h.

Top module: `prog_tap_scrambler`

## Requirements
- R1: While `srst` is high at a clock edge, the history register takes `seed`, the tap register takes 48h, and `out_valid` is low on the following cycle.
- R2: The tap register sits at configuration address 1Ch. A write there stores all 8 bits, and `cfg_rdata` returns them while `cfg_addr` is 1Ch. `cfg_rdata` is 0 for any other address. A write to any other address leaves the tap register unchanged.
- R3: Bit 7 of the tap register has no effect on the output sequence.
- R4: In scramble mode (`descramble` = 0), an accepted bit d produces the output o = d XOR parity(history AND mask[6:0]). Mask bit k selects the stage holding the bit accepted k+1 steps earlier. The history then shifts left one place, with o entering bit 0.
- R5: In descramble mode (`descramble` = 1), the output has the same form as in R4, but the received bit d enters history bit 0.
- R6: With mask bits 6:0 all zero, the output equals the input bit.
- R7: In a cycle with `bit_en` low, the history does not change, `bit_out` holds its value, and `out_valid` is low on the next cycle.
- R8: Data scrambled with a mask and then descrambled with the same mask is recovered exactly from the eighth bit onward, even when the two seeds differ.
- R9: `bit_out` and `out_valid` change one clock after the edge that accepts the bit, and `out_valid` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| seed | input | 7 | Value loaded into the history on reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| descramble | input | 1 | 0 = scramble, 1 = descramble |
| bit_en | input | 1 | Accept `bit_in` this cycle |
| bit_in | input | 1 | Serial data in |
| bit_out | output | 1 | Serial data out, registered |
| out_valid | output | 1 | `bit_out` holds a new result |

## Verification
Random bit streams are scrambled under several masks: the default, the full mask, a single near tap, a single far tap and a middle group. Each mask exposes a different tap position or parity width to a model built from the requirements. A stream of zeros after reset separates a correctly loaded seed from a cleared history. Two further pairs of runs use the same data and seed each time. One pair differs only in mask bit 7. The other goes through a scramble and then a descramble from a different seed. Together they show that bit 7 is inert and that the self-synchronizing recovery holds. An all-zero mask and idle gaps between bits check the pass-through case and the hold behaviour.

// File: rtl/scr_pkg.sv
package scr_pkg;
   typedef enum logic {
      MODE_SCRAMBLE   = 1'b0,
      MODE_DESCRAMBLE = 1'b1
   } scr_mode_e;

   localparam int          DEF_STAGES     = 7;
   localparam int          DEF_CFG_W      = 8;
   localparam int          DEF_ADDR_W     = 8;
   localparam logic [7:0]  DEF_TAP_ADDR   = 8'h1C;
   localparam logic [7:0]  DEF_RESET_TAPS = 8'h48;
endpackage

// File: rtl/scr_tap_reg.sv
module scr_tap_reg #(
   parameter int               DATA_W    = 8,
   parameter int               ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] MY_ADDR  = 8'h1C,
   parameter logic [DATA_W-1:0] RESET_VAL = 8'h48
) (
   input  logic              clk,
   input  logic              srst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] taps_q
);
   logic hit;

   assign hit = (addr == MY_ADDR);

   always_ff @(posedge clk) begin
      if (srst)
         taps_q <= RESET_VAL;
      else if (wr_en && hit)
         taps_q <= wdata;
   end

   assign rdata = hit ? taps_q : '0;
endmodule

// File: rtl/scr_parity.sv
module scr_parity #(
   parameter int W = 7
) (
   input  logic [W-1:0] vec,
   input  logic [W-1:0] sel,
   output logic         par
);
   logic [W:0] chain;

   assign chain[0] = 1'b0;
   for (genvar i = 0; i < W; i++) begin : g_tap
      assign chain[i+1] = chain[i] ^ (vec[i] & sel[i]);
   end
   assign par = chain[W];
endmodule

// File: rtl/scr_shift_core.sv
module scr_shift_core
   import scr_pkg::*;
#(
   parameter int STAGES         = 7,
   parameter bit REGISTERED_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              srst,
   input  logic [STAGES-1:0] seed,
   input  logic [STAGES-1:0] mask,
   input  logic              mode,
   input  logic              en,
   input  logic              din,
   output logic              dout,
   output logic              dvalid,
   output logic [STAGES-1:0] state_o
);
   logic [STAGES-1:0] state_q;
   logic              fb_par;
   logic              scr_bit;
   logic              shift_in;
   scr_mode_e         mode_e;

   assign mode_e = scr_mode_e'(mode);

   scr_parity #(.W(STAGES)) u_par (
      .vec (state_q),
      .sel (mask),
      .par (fb_par)
   );

   assign scr_bit  = din ^ fb_par;
   assign shift_in = (mode_e == MODE_DESCRAMBLE) ? din : scr_bit;

   always_ff @(posedge clk) begin
      if (srst)
         state_q <= seed;
      else if (en)
         state_q <= {state_q[STAGES-2:0], shift_in};
   end

   assign state_o = state_q;

   if (REGISTERED_OUT) begin : g_reg_out
      logic out_q;
      logic vld_q;
      always_ff @(posedge clk) begin
         if (srst) begin
            out_q <= 1'b0;
            vld_q <= 1'b0;
         end else begin
            vld_q <= en;
            if (en)
               out_q <= scr_bit;
         end
      end
      assign dout   = out_q;
      assign dvalid = vld_q;
   end else begin : g_comb_out
      assign dout   = scr_bit;
      assign dvalid = en;
   end
endmodule

// File: rtl/prog_tap_scrambler.sv
module prog_tap_scrambler
   import scr_pkg::*;
#(
   parameter int                   STAGES         = DEF_STAGES,
   parameter int                   CFG_W          = DEF_CFG_W,
   parameter int                   ADDR_W         = DEF_ADDR_W,
   parameter logic [ADDR_W-1:0]    TAP_ADDR       = DEF_TAP_ADDR,
   parameter logic [CFG_W-1:0]     RESET_TAPS     = DEF_RESET_TAPS,
   parameter bit                   REGISTERED_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              srst,
   input  logic [STAGES-1:0] seed,
   input  logic              cfg_wr_en,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              descramble,
   input  logic              bit_en,
   input  logic              bit_in,
   output logic              bit_out,
   output logic              out_valid
);
   if (STAGES < 2 || STAGES > CFG_W) begin : g_bad_stages
      $error("prog_tap_scrambler: STAGES must be in 2..CFG_W");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("prog_tap_scrambler: ADDR_W must be positive");
   end

   logic [CFG_W-1:0]  taps_q;
   logic [STAGES-1:0] state_q;

   scr_tap_reg #(
      .DATA_W    (CFG_W),
      .ADDR_W    (ADDR_W),
      .MY_ADDR   (TAP_ADDR),
      .RESET_VAL (RESET_TAPS)
   ) u_taps (
      .clk    (clk),
      .srst   (srst),
      .wr_en  (cfg_wr_en),
      .addr   (cfg_addr),
      .wdata  (cfg_wdata),
      .rdata  (cfg_rdata),
      .taps_q (taps_q)
   );

   scr_shift_core #(
      .STAGES         (STAGES),
      .REGISTERED_OUT (REGISTERED_OUT)
   ) u_core (
      .clk     (clk),
      .srst    (srst),
      .seed    (seed),
      .mask    (taps_q[STAGES-1:0]),
      .mode    (descramble),
      .en      (bit_en),
      .din     (bit_in),
      .dout    (bit_out),
      .dvalid  (out_valid),
      .state_o (state_q)
   );
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
   parameter int STAGES         = 7,
   parameter bit REGISTERED_OUT = 1'b1
) (
   input logic              clk,
   input logic              srst,
   input logic [STAGES-1:0] seed,
   input logic              bit_en,
   input logic              bit_in,
   input logic              descramble,
   input logic              bit_out,
   input logic              out_valid,
   input logic [STAGES-1:0] taps,
   input logic [STAGES-1:0] state
);
   // R1: reset loads the seed and clears the valid flag
   p_seed_load_r1: assert property (@(posedge clk)
      srst |=> (state == $past(seed)) && !out_valid);

   // R4: history shifts left by one on every accepted bit
   p_shift_left_r4: assert property (@(posedge clk) disable iff (srst)
      bit_en |=> state[STAGES-1:1] == $past(state[STAGES-2:0]));

   // R5: descramble feeds the received bit back
   p_dsc_feed_r5: assert property (@(posedge clk) disable iff (srst)
      (bit_en && descramble) |=> state[0] == $past(bit_in));

   // R7: idle cycles leave the history alone
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (srst)
      !bit_en |=> $stable(state));

   if (REGISTERED_OUT) begin : g_timed
      // R4: scramble feeds its own output back
      p_scr_feed_r4: assert property (@(posedge clk) disable iff (srst)
         (bit_en && !descramble) |=> state[0] == bit_out);

      // R6: an empty mask passes data straight through
      p_passthru_r6: assert property (@(posedge clk) disable iff (srst)
         (bit_en && taps == '0) |=> bit_out == $past(bit_in));

      // R7: output holds and valid stays low when idle
      p_idle_out_r7: assert property (@(posedge clk) disable iff (srst)
         !bit_en |=> !out_valid && $stable(bit_out));

      // R9: one-cycle latency from accept to valid
      p_latency_r9: assert property (@(posedge clk) disable iff (srst)
         bit_en |=> out_valid);
   end
endmodule

bind prog_tap_scrambler scr_checker #(
   .STAGES         (STAGES),
   .REGISTERED_OUT (REGISTERED_OUT)
) u_chk (
   .clk        (clk),
   .srst       (srst),
   .seed       (seed),
   .bit_en     (bit_en),
   .bit_in     (bit_in),
   .descramble (descramble),
   .bit_out    (bit_out),
   .out_valid  (out_valid),
   .taps       (taps_q[STAGES-1:0]),
   .state      (state_q)
);

// File: tb/test_prog_tap_scrambler.sv
`timescale 1ns/1ps
module test_prog_tap_scrambler;
   logic       clk = 1'b0;
   logic       srst = 1'b1;
   logic [6:0] seed = 7'h00;
   logic       cfg_wr_en = 1'b0;
   logic [7:0] cfg_addr = 8'h00;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic       descramble = 1'b0;
   logic       bit_en = 1'b0;
   logic       bit_in = 1'b0;
   logic       bit_out;
   logic       out_valid;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [6:0] m_state;
   logic [7:0] m_taps;

   always #2 clk = ~clk;

   prog_tap_scrambler i_prog_tap_scrambler (
      .clk(clk), .srst(srst), .seed(seed),
      .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .descramble(descramble),
      .bit_en(bit_en), .bit_in(bit_in), .bit_out(bit_out), .out_valid(out_valid)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   // Reference from R4/R5: parity of tapped stages, then shift left
   function automatic logic model_step(input logic din);
      logic o;
      o = din ^ (^(m_state & m_taps[6:0]));
      m_state = {m_state[5:0], descramble ? din : o};
      return o;
   endfunction

   task automatic do_reset(input logic [6:0] s);
      @(negedge clk);
      srst = 1'b1;
      seed = s;
      @(negedge clk);
      srst = 1'b0;
      m_state = s;
      m_taps  = 8'h48;
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1;
      cfg_addr  = a;
      cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      if (a == 8'h1C) m_taps = d;
   endtask

   task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
   endtask

   // Drive one bit; result sampled at the next falling edge (R9)
   task automatic send_bit(input logic din, output logic got);
      @(negedge clk);
      bit_en = 1'b1;
      bit_in = din;
      @(negedge clk);
      bit_en = 1'b0;
      got = bit_out;
      check("R9", "out_valid after accept", 32'(out_valid), 32'd1);
   endtask

   task automatic t_reset();
      logic [7:0] rd;
      logic got, exp;
      do_reset(7'h55);
      descramble = 1'b0;
      check("R1", "out_valid after reset", 32'(out_valid), 32'd0);
      cfg_read(8'h1C, rd);
      check("R1", "default taps", 32'(rd), 32'h48);
      for (int i = 0; i < 10; i++) begin
         send_bit(1'b0, got);
         exp = model_step(1'b0);
         check("R1", "seeded output", 32'(got), 32'(exp));
      end
   endtask

   task automatic t_regs();
      logic [7:0] rd;
      do_reset(7'h01);
      cfg_write(8'h1C, 8'hA3);
      cfg_read(8'h1C, rd);
      check("R2", "tap readback", 32'(rd), 32'hA3);
      cfg_write(8'h20, 8'h11);
      cfg_read(8'h1C, rd);
      check("R2", "foreign write ignored", 32'(rd), 32'hA3);
      cfg_read(8'h20, rd);
      check("R2", "other address reads 0", 32'(rd), 32'h00);
   endtask

   task automatic t_scramble(input logic [7:0] mask, input logic [6:0] s, input int n);
      logic got, exp, d;
      do_reset(s);
      descramble = 1'b0;
      cfg_write(8'h1C, mask);
      for (int i = 0; i < n; i++) begin
         d = 1'($urandom);
         send_bit(d, got);
         exp = model_step(d);
         check(mask == 8'h00 ? "R6" : "R4", "scrambled bit", 32'(got), 32'(exp));
         if (mask[6:0] == 7'h00)
            check("R6", "pass-through", 32'(got), 32'(d));
      end
   endtask

   task automatic t_bit7();
      logic [63:0] data, out_a, out_b;
      logic [7:0] rd;
      logic got;
      data = {$urandom, $urandom};
      do_reset(7'h2B);
      descramble = 1'b0;
      cfg_write(8'h1C, 8'hC8);
      cfg_read(8'h1C, rd);
      check("R2", "bit7 stored", 32'(rd), 32'hC8);
      for (int i = 0; i < 64; i++) begin send_bit(data[i], got); out_a[i] = got; end
      do_reset(7'h2B);
      cfg_write(8'h1C, 8'h48);
      for (int i = 0; i < 64; i++) begin send_bit(data[i], got); out_b[i] = got; end
      check("R3", "bit7 inert (lo)", out_a[31:0], out_b[31:0]);
      check("R3", "bit7 inert (hi)", out_a[63:32], out_b[63:32]);
   endtask

   task automatic t_hold();
      logic got, exp, held;
      do_reset(7'h3C);
      descramble = 1'b0;
      cfg_write(8'h1C, 8'h7F);
      send_bit(1'b1, got);
      exp = model_step(1'b1);
      check("R7", "bit before gap", 32'(got), 32'(exp));
      held = got;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check("R7", "valid low while idle", 32'(out_valid), 32'd0);
         check("R7", "output held", 32'(bit_out), 32'(held));
      end
      for (int i = 0; i < 12; i++) begin
         send_bit(1'(i % 3 == 0), got);
         exp = model_step(1'(i % 3 == 0));
         check("R7", "state kept across gap", 32'(got), 32'(exp));
      end
   endtask

   task automatic t_loopback(input logic [7:0] mask);
      logic [47:0] data, line;
      logic got, exp;
      data = {16'($urandom), $urandom};
      do_reset(7'h13);
      descramble = 1'b0;
      cfg_write(8'h1C, mask);
      for (int i = 0; i < 48; i++) begin
         send_bit(data[i], got);
         line[i] = got;
         void'(model_step(data[i]));
      end
      do_reset(7'h6A);
      descramble = 1'b1;
      cfg_write(8'h1C, mask);
      for (int i = 0; i < 48; i++) begin
         send_bit(line[i], got);
         exp = model_step(line[i]);
         check("R5", "descrambled bit", 32'(got), 32'(exp));
         if (i >= 7) check("R8", "recovered data", 32'(got), 32'(data[i]));
      end
      descramble = 1'b0;
   endtask

   initial begin
      t_reset();
      t_regs();
      t_scramble(8'h48, 7'h7F, 40);
      t_scramble(8'h7F, 7'h11, 40);
      t_scramble(8'h01, 7'h40, 30);
      t_scramble(8'h40, 7'h05, 30);
      t_scramble(8'h3C, 7'h5A, 30);
      t_scramble(8'h00, 7'h33, 20);
      t_bit7();
      t_hold();
      t_loopback(8'h48);
      t_loopback(8'h65);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule